// File: doc/BRIEF.md
# Interleaved Bank Refill Unit

This unit refills cache lines from a main memory made of `NUM_BANKS` independent, word-wide banks. A line of `NUM_BANKS` words is striped across the banks: word k of every line lives in bank k. When the cache hands over a block address, the unit drives that address to every bank at once, for one bus cycle. All banks then run their array access side by side for the same `ACCESS_LAT` cycles. After that the finished words leave over a single one-word bus on consecutive cycles, word 0 first.

The refill costs one address cycle, plus one shared access, plus one transfer cycle per word: 1 + `ACCESS_LAT` + `NUM_BANKS` bus cycles. A bank-at-a-time scheme would pay the access once per word instead. With the defaults (4 banks, 15-cycle access) a refill takes 20 bus cycles.

The request side is valid/ready. `req_ready` is high only while the unit is idle. A request held valid while the unit is busy simply waits. The response side has no back-pressure: the consumer must take every word in the cycle it is offered. Each word carries a strobe, its index within the line, and a last flag on the final word. Bank contents are a fixed, computed fill pattern, because writes are outside this block's scope. `NUM_BANKS` must be a power of two and at least 2, and `ACCESS_LAT` must be at least 1.

Top module: `ilv_refill_top`

## Requirements
- R1: During and right after reset, `rsp_valid` and `rsp_last` are 0 and `req_ready` is 1.
- R2: Word k of block b comes from bank k. Its value is the low `WORD_W` bits of ((b·NUM_BANKS + k)·0x9E3779B1 mod 2^32) XOR 0x5A5AC3C3.
- R3: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1, and `req_blk` is captured at that edge. Changes to `req_blk` or `req_valid` after that edge have no effect on the refill in progress.
- R4: In the single cycle after acceptance, the captured block address goes to all banks at once. All banks then finish together, `ACCESS_LAT` cycles later.
- R5: `rsp_valid` first rises `ACCESS_LAT + 1` rising edges after the accepting edge. It then stays high for exactly `NUM_BANKS` consecutive cycles, with `rsp_idx` = 0, 1, …, `NUM_BANKS`-1 in order. The whole refill spans 1 + `ACCESS_LAT` + `NUM_BANKS` cycles.
- R6: During the address and access cycles, `rsp_valid` and `rsp_last` are 0 and `rsp_data` is 0.
- R7: `rsp_last` is 1 only together with word `NUM_BANKS`-1, and it is followed by an idle cycle.
- R8: `req_ready` is 0 from the accepting edge until the last word has been delivered, and 1 again in the cycle after the last word. A request held valid meanwhile is accepted at the first edge where ready is 1.
- R9: Reset during a refill abandons it. No word of that refill ever appears, and the unit accepts a new request afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Refill request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_blk | input | BLK_W | Block (line) address to fetch |
| rsp_valid | output | 1 | Word strobe on the return bus |
| rsp_idx | output | log2(NUM_BANKS) | Word index within the line |
| rsp_data | output | WORD_W | Returned word, zero when no word is offered |
| rsp_last | output | 1 | Final word of the line |

## Verification
Some properties are checked by assertions on every cycle:
- the address strobe lasts exactly one cycle;
- the banks become ready in lockstep and never receive a new address while busy;
- exactly `ACCESS_LAT` edges pass from the broadcast to the first word;
- word indices start at 0 and step by one;
- the unit is idle right after the last word.

Other behaviour can only be shown by the bench's scenarios: the stored value of each word, the fact that a changed block address after acceptance is ignored, the exact re-acceptance of a held request, and the silent abandonment of a refill cut short by reset.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ADDR,
    SQ_WAIT,
    SQ_XFER
  } sq_state_e;

  // Fixed fill pattern of the behavioural bank arrays, keyed by word address.
  function automatic logic [31:0] ilv_fill(input logic [31:0] waddr);
    return (waddr * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int BANK_ID    = 0,
  parameter int NUM_BANKS  = 4,
  parameter int ROW_W      = 8,
  parameter int WORD_W     = 32,
  parameter int ACCESS_LAT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_stb,
  input  logic [ROW_W-1:0]  addr_row,
  output logic              bank_rdy,
  output logic [WORD_W-1:0] bank_word
);

  localparam int ROWS  = 1 << ROW_W;
  localparam int CNT_W = $clog2(ACCESS_LAT + 1);

  logic [WORD_W-1:0] cells [ROWS];
  logic [ROW_W-1:0]  row_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_cell
    assign cells[r] = WORD_W'(ilv_pkg::ilv_fill(32'(r * NUM_BANKS + BANK_ID)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (addr_stb) begin
      row_q  <= addr_row;
      cnt_q  <= CNT_W'(ACCESS_LAT - 1);
      busy_q <= (ACCESS_LAT > 1) ? 1'b1 : 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign bank_rdy  = !busy_q;
  assign bank_word = cells[row_q];

  AST_BANK_NO_RESTRIKE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |-> !busy_q); // R4
  AST_BANK_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(row_q)); // R3

endmodule

// File: rtl/ilv_seq.sv
module ilv_seq #(
  parameter int NUM_BANKS  = 4,
  parameter int ACCESS_LAT = 15,
  parameter int IDX_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             addr_stb,
  input  logic             all_rdy,
  output logic             xfer_valid,
  output logic [IDX_W-1:0] xfer_idx,
  output logic             xfer_last
);

  import ilv_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);
  localparam int CHK_W = $clog2(ACCESS_LAT + 2) + 1;

  sq_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      SQ_IDLE: if (req_valid) state_d = SQ_ADDR;
      SQ_ADDR: state_d = SQ_WAIT;
      SQ_WAIT: if (all_rdy) begin
        state_d = SQ_XFER;
        idx_d   = '0;
      end
      SQ_XFER: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign req_ready  = (state_q == SQ_IDLE);
  assign addr_stb   = (state_q == SQ_ADDR);
  assign xfer_valid = (state_q == SQ_XFER);
  assign xfer_idx   = xfer_valid ? idx_q : '0;
  assign xfer_last  = xfer_valid && (idx_q == LAST_IDX);

  // Edges counted from the broadcast to the first word, for the latency check.
  logic [CHK_W-1:0] chk_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_cnt_q <= '0;
    else if (addr_stb) chk_cnt_q <= '0;
    else if (!xfer_valid && chk_cnt_q <= CHK_W'(ACCESS_LAT)) chk_cnt_q <= chk_cnt_q + 1'b1;
  end

  AST_ACCEPT_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> addr_stb); // R3
  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> !addr_stb); // R4
  AST_LAT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_valid) |-> (chk_cnt_q == CHK_W'(ACCESS_LAT))); // R5
  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_valid) |-> (xfer_idx == '0)); // R5
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_last) |=> (xfer_valid && xfer_idx == $past(xfer_idx) + 1'b1)); // R5
  AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |=> (!xfer_valid && req_ready)); // R7

endmodule

// File: rtl/ilv_word_mux.sv
module ilv_word_mux #(
  parameter int NUM_BANKS = 4,
  parameter int WORD_W    = 32,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_BANKS*WORD_W-1:0] words,
  input  logic                        en,
  input  logic [IDX_W-1:0]            sel,
  output logic [WORD_W-1:0]           word_out
);

  always_comb begin
    word_out = '0;
    if (en) word_out = words[sel * WORD_W +: WORD_W];
  end

endmodule

// File: rtl/ilv_refill_top.sv
module ilv_refill_top #(
  parameter int NUM_BANKS  = 4,
  parameter int WORD_W     = 32,
  parameter int BLK_W      = 8,
  parameter int ACCESS_LAT = 15
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [BLK_W-1:0]             req_blk,
  output logic                         rsp_valid,
  output logic [$clog2(NUM_BANKS)-1:0] rsp_idx,
  output logic [WORD_W-1:0]            rsp_data,
  output logic                         rsp_last
);

  localparam int IDX_W = $clog2(NUM_BANKS);

  logic                        addr_stb;
  logic                        all_rdy;
  logic [BLK_W-1:0]            blk_q;
  logic [NUM_BANKS-1:0]        bank_rdy;
  logic [NUM_BANKS*WORD_W-1:0] bank_words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= '0;
    else if (req_valid && req_ready) blk_q <= req_blk;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    ilv_bank #(
      .BANK_ID(g), .NUM_BANKS(NUM_BANKS), .ROW_W(BLK_W),
      .WORD_W(WORD_W), .ACCESS_LAT(ACCESS_LAT)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .addr_row(blk_q),
      .bank_rdy(bank_rdy[g]), .bank_word(bank_words[g*WORD_W +: WORD_W])
    );
  end

  assign all_rdy = &bank_rdy;

  ilv_seq #(.NUM_BANKS(NUM_BANKS), .ACCESS_LAT(ACCESS_LAT), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .addr_stb(addr_stb), .all_rdy(all_rdy), .xfer_valid(rsp_valid),
    .xfer_idx(rsp_idx), .xfer_last(rsp_last)
  );

  ilv_word_mux #(.NUM_BANKS(NUM_BANKS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_mux (
    .words(bank_words), .en(rsp_valid), .sel(rsp_idx), .word_out(rsp_data)
  );

  AST_BANKS_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (&bank_rdy) || !(|bank_rdy)); // R4
  AST_BUSY_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(req_valid && req_ready)); // R8

endmodule

// File: tb/ilv_refill_top_tb.sv
module ilv_refill_top_tb;

  localparam int NB  = 4;
  localparam int WW  = 32;
  localparam int BW  = 8;
  localparam int LAT = 15;
  localparam int IW  = 2;
  localparam int NV  = 8;

  // Stimulus table: block address, and whether a follow-up request is held valid.
  localparam logic [BW-1:0] VEC_BLK [NV] = '{8'h00, 8'h01, 8'h3F, 8'hFF, 8'h80, 8'h55, 8'hAA, 8'h01};
  localparam bit            VEC_HOLD [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [BW-1:0] req_blk;
  logic          rsp_valid;
  logic [IW-1:0] rsp_idx;
  logic [WW-1:0] rsp_data;
  logic          rsp_last;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ilv_refill_top #(.NUM_BANKS(NB), .WORD_W(WW), .BLK_W(BW), .ACCESS_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_blk(req_blk), .rsp_valid(rsp_valid), .rsp_idx(rsp_idx),
    .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  function automatic logic [WW-1:0] exp_word(input logic [BW-1:0] b, input int k);
    logic [31:0] a;
    a = 32'(b) * 32'(NB) + 32'(k);
    return WW'((a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the last word.
  task automatic run_block(input logic [BW-1:0] blk, input bit hold, input logic [BW-1:0] next_blk);
    bit bad;
    req_valid = 1'b1;
    req_blk   = blk;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    if (hold) req_blk = next_blk;
    else begin
      req_valid = 1'b0;
      req_blk   = ~blk;
    end
    bad = 1'b0;
    for (int n = 1; n <= LAT + 1; n++) begin
      if (rsp_valid || rsp_last || req_ready || rsp_data != '0) bad = 1'b1;
      @(negedge clk);
    end
    check(!bad, "R6 R8", "quiet during address and access", 64'(bad), 64'(0));
    for (int k = 0; k < NB; k++) begin
      check(rsp_valid && rsp_idx == IW'(k) && rsp_last == (k == NB - 1) && !req_ready,
            "R4 R5 R7", $sformatf("word %0d strobe/idx/last/ready", k),
            {rsp_valid, rsp_last, req_ready, 32'(rsp_idx)},
            {1'b1, (k == NB - 1) ? 1'b1 : 1'b0, 1'b0, 32'(k)});
      check(rsp_data == exp_word(blk, k), "R2 R3",
            $sformatf("block %0h word %0d data", blk, k), 64'(rsp_data), 64'(exp_word(blk, k)));
      @(negedge clk);
    end
    check(req_ready && !rsp_valid, "R8", "ready again after last word",
          {req_ready, rsp_valid}, 2'b10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit bad;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_blk   = '0;
    repeat (3) @(negedge clk);
    check(!rsp_valid && !rsp_last, "R1", "outputs idle in reset", {rsp_valid, rsp_last}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R1", "ready after reset", {req_ready, rsp_valid}, 2'b10);

    for (int v = 0; v < NV; v++)
      run_block(VEC_BLK[v], VEC_HOLD[v], VEC_BLK[(v + 1) % NV]);

    // R9: reset in the middle of a refill.
    req_valid = 1'b1;
    req_blk   = 8'h12;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!rsp_valid && req_ready, "R9", "reset aborts refill", {rsp_valid, req_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    bad = 1'b0;
    repeat (LAT + NB + 3) begin
      if (rsp_valid) bad = 1'b1;
      @(negedge clk);
    end
    check(!bad, "R9", "no words from abandoned refill", 64'(bad), 64'(0));
    run_block(8'h12, 1'b0, 8'h00);  // R9: unit usable after the abort

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule